// File: doc/BRIEF.md
# Sliding-Window Multiply-Accumulate Filter

This block applies a one-dimensional filter to a stream of pixels, sixteen output points at a time. Pixels come in as chunks of sixteen on a wide data port. Each shift strobe pushes one chunk into a forty-entry window register and discards the oldest sixteen entries. A compute strobe then evaluates sixteen overlapping windows of the register in parallel. Output lane k starts its window at entry k, multiplies N consecutive pixels by a shared set of signed coefficients, and adds up the products. The tap count N is chosen at run time.

The same hardware serves horizontal and vertical filtering. The caller decides the order in which pixels are fed, and keeps the results once they are valid. With the largest tap count of fifteen, lane 15 reaches entry 29. Entries 30 to 39 therefore only hold pixels that will be needed after the next shift.

Top module: `slide_filt`

## Requirements
- R1: After reset every window entry is zero, every result lane reads zero and `valid_o` is low.
- R2: On a cycle with `shift_i` high, entry i takes the old entry i+16 for i below 24, and entry 24+j takes chunk pixel j (bits j*10 of `chunk_i`). The old entries 0 to 15 are lost.
- R3: While `shift_i` is low, the window contents do not change.
- R4: Result lane k (bits k*24 of `res_o`, signed 24-bit two's complement) equals the sum, over j from 0 to N-1, of coefficient j times entry k+j. Pixels are unsigned 10-bit. Coefficient j is signed 10-bit two's complement, taken from bits j*10 of `coef_i`.
- R5: N is the unsigned value of `taps_i` (1 to 15). Coefficients with index N or above have no effect on any result.
- R6: A compute with `taps_i` equal to 0 drives every result lane to zero.
- R7: Results from a compute strobe appear on the clock edge that samples the strobe. `valid_o` is high for exactly the cycle after each cycle with `compute_i` high, and low otherwise.
- R8: Without a compute strobe, `res_o` keeps its value, even when pixels, coefficients or the tap count change.
- R9: When shift and compute are both high in the same cycle, the results use the window contents from before the shift.
- R10: The extreme operands (all pixels 1023, all fifteen coefficients -512 or +511) give exact results, with no wrap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| chunk_i | input | 160 | Sixteen incoming 10-bit pixels, pixel j at bits j*10 |
| shift_i | input | 1 | Push the chunk into the window |
| taps_i | input | 4 | Tap count N |
| coef_i | input | 150 | Fifteen signed 10-bit coefficients, coefficient j at bits j*10 |
| compute_i | input | 1 | Evaluate all lanes and register the results |
| res_o | output | 384 | Sixteen signed 24-bit results, lane k at bits k*24 |
| valid_o | output | 1 | Results updated by the previous cycle's compute |

## Verification
A shift changes the window on the edge that samples it. A compute result and its `valid_o` appear on the edge that samples the compute strobe. So every result is due one edge after the strobe. The bench drives strobes just after a falling edge, waits one rising edge, and compares on the next falling edge against its own model of the window and its own sum of products. For the hold and ignore cases (R3, R5, R8), the bench lets further edges pass with the strobe low, then checks that the outputs have not moved.

// File: rtl/slf_pkg.sv
package slf_pkg;

  // Product of one unsigned pixel and one signed coefficient.
  // Operands up to 16 bits wide.
  function automatic logic signed [31:0] tap_term(input logic [15:0] pix,
                                                  input logic signed [15:0] cf);
    return signed'({16'd0, pix}) * 32'(cf);
  endfunction

endpackage

// File: rtl/slf_shiftreg.sv
module slf_shiftreg #(
  parameter int LANES = 16,
  parameter int DEPTH = 40,
  parameter int PIX_W = 10
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   shift_i,
  input  logic [LANES*PIX_W-1:0] chunk_i,
  output logic [DEPTH*PIX_W-1:0] win_o
);
  localparam int TOTAL_W = DEPTH * PIX_W;
  localparam int CHUNK_W = LANES * PIX_W;

  logic [TOTAL_W-1:0] win_q;

  // Entry 0 is the oldest. New pixels enter at the top.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      win_q <= '0;
    else if (shift_i)
      win_q <= {chunk_i, win_q[TOTAL_W-1:CHUNK_W]};
  end

  assign win_o = win_q;
endmodule

// File: rtl/slf_lane.sv
module slf_lane #(
  parameter int PIX_W    = 10,
  parameter int COEF_W   = 10,
  parameter int ACC_W    = 24,
  parameter int MAX_TAPS = 15,
  parameter int CNT_W    = 4
) (
  input  logic [MAX_TAPS*PIX_W-1:0]  win_i,
  input  logic [MAX_TAPS*COEF_W-1:0] coef_i,
  input  logic [CNT_W-1:0]           taps_i,
  output logic signed [ACC_W-1:0]    sum_o
);
  import slf_pkg::*;

  always_comb begin
    sum_o = '0;
    for (int j = 0; j < MAX_TAPS; j++) begin
      if (j < int'(taps_i))
        sum_o = sum_o + ACC_W'(tap_term(16'(win_i[j*PIX_W +: PIX_W]),
                                        16'(signed'(coef_i[j*COEF_W +: COEF_W]))));
    end
  end
endmodule

// File: rtl/slide_filt.sv
module slide_filt #(
  parameter int LANES    = 16,
  parameter int DEPTH    = 40,
  parameter int PIX_W    = 10,
  parameter int COEF_W   = 10,
  parameter int ACC_W    = 24,
  parameter int MAX_TAPS = 15,
  parameter int CNT_W    = $clog2(MAX_TAPS + 1)
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic [LANES*PIX_W-1:0]       chunk_i,
  input  logic                         shift_i,
  input  logic [CNT_W-1:0]             taps_i,
  input  logic [MAX_TAPS*COEF_W-1:0]   coef_i,
  input  logic                         compute_i,
  output logic [LANES*ACC_W-1:0]       res_o,
  output logic                         valid_o
);
  localparam int WIN_W = MAX_TAPS * PIX_W;

  logic [DEPTH*PIX_W-1:0] win;
  logic                   shift_evt;
  logic                   compute_evt;
  logic signed [ACC_W-1:0] lane_sum [LANES];
  logic [LANES*ACC_W-1:0] res_q;
  logic                   valid_q;

  assign shift_evt   = shift_i;
  assign compute_evt = compute_i;

  slf_shiftreg #(.LANES(LANES), .DEPTH(DEPTH), .PIX_W(PIX_W)) u_win (
    .clk    (clk),
    .rst_n  (rst_n),
    .shift_i(shift_evt),
    .chunk_i(chunk_i),
    .win_o  (win)
  );

  for (genvar k = 0; k < LANES; k++) begin : g_lane
    slf_lane #(
      .PIX_W(PIX_W), .COEF_W(COEF_W), .ACC_W(ACC_W),
      .MAX_TAPS(MAX_TAPS), .CNT_W(CNT_W)
    ) u_lane (
      .win_i (win[k*PIX_W +: WIN_W]),
      .coef_i(coef_i),
      .taps_i(taps_i),
      .sum_o (lane_sum[k])
    );
  end

  // The window read here is the one from before any same-cycle shift.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_q   <= '0;
      valid_q <= 1'b0;
    end else begin
      valid_q <= compute_evt;
      if (compute_evt)
        for (int k = 0; k < LANES; k++)
          res_q[k*ACC_W +: ACC_W] <= lane_sum[k];
    end
  end

  assign res_o   = res_q;
  assign valid_o = valid_q;
endmodule

// File: rtl/slf_check.sv
module slf_check #(
  parameter int LANES    = 16,
  parameter int DEPTH    = 40,
  parameter int PIX_W    = 10,
  parameter int ACC_W    = 24,
  parameter int CNT_W    = 4
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   shift_i,
  input logic                   compute_i,
  input logic [CNT_W-1:0]       taps_i,
  input logic [LANES*PIX_W-1:0] chunk_i,
  input logic [DEPTH*PIX_W-1:0] win,
  input logic [LANES*ACC_W-1:0] res_o,
  input logic                   valid_o
);
  localparam int CW = LANES * PIX_W;

  // R7
  compute_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    compute_i |=> valid_o);

  // R7
  idle_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !compute_i |=> !valid_o);

  // R8
  hold_res_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !compute_i |=> $stable(res_o));

  // R3
  hold_win_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !shift_i |=> $stable(win));

  // R2
  shift_move_chk: assert property (@(posedge clk) disable iff (!rst_n)
    shift_i |=> win[CW-1:0] == $past(win[2*CW-1 -: CW]));

  // R2
  shift_new_chk: assert property (@(posedge clk) disable iff (!rst_n)
    shift_i |=> win[DEPTH*PIX_W-1 -: CW] == $past(chunk_i));

  // R6
  zero_taps_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (compute_i && taps_i == '0) |=> res_o == '0);
endmodule

bind slide_filt slf_check #(
  .LANES(LANES), .DEPTH(DEPTH), .PIX_W(PIX_W), .ACC_W(ACC_W), .CNT_W(CNT_W)
) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .shift_i  (shift_evt),
  .compute_i(compute_evt),
  .taps_i   (taps_i),
  .chunk_i  (chunk_i),
  .win      (win),
  .res_o    (res_o),
  .valid_o  (valid_o)
);

// File: tb/slide_filt_tb.sv
module slide_filt_tb;
  localparam int CLK_PERIOD = 10;
  localparam int L = 16, D = 40, PW = 10, CWD = 10, AW = 24, T = 15;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [L*PW-1:0] chunk = '0;
  logic shift = 1'b0, compute = 1'b0;
  logic [3:0] taps = '0;
  logic [T*CWD-1:0] coef = '0;
  logic [L*AW-1:0] res;
  logic valid;

  int checks = 0, fails = 0;
  bit done = 0;
  int ref_e [D];
  int cf [T];
  int ncur = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  slide_filt u_dut (
    .clk(clk), .rst_n(rst_n), .chunk_i(chunk), .shift_i(shift),
    .taps_i(taps), .coef_i(coef), .compute_i(compute),
    .res_o(res), .valid_o(valid)
  );

  function automatic int pat(int seed, int j);
    return (seed * 37 + j * 101 + seed * j * 7) % 1024;
  endfunction

  function automatic int ref_lane(int k, int n);
    int s = 0;
    for (int j = 0; j < n; j++) s += cf[j] * ref_e[k + j];
    return s;
  endfunction

  function automatic int lane_out(int k);
    logic signed [AW-1:0] v;
    v = res[k*AW +: AW];
    return int'(v);
  endfunction

  task automatic check(bit ok, string req, int got, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: got %0d expected %0d", req, got, exp);
    end
  endtask

  task automatic pack_coef();
    for (int j = 0; j < T; j++) coef[j*CWD +: CWD] = 10'(cf[j]);
  endtask

  task automatic do_shift(int seed);
    for (int j = 0; j < L; j++) chunk[j*PW +: PW] = 10'(pat(seed, j));
    shift = 1'b1;
    @(posedge clk); @(negedge clk);
    shift = 1'b0;
    for (int i = 0; i < D - L; i++) ref_e[i] = ref_e[i + L];
    for (int j = 0; j < L; j++) ref_e[D - L + j] = pat(seed, j);
  endtask

  task automatic do_compute(int n);
    taps = 4'(n); ncur = n; pack_coef();
    compute = 1'b1;
    @(posedge clk); @(negedge clk);
    compute = 1'b0;
  endtask

  task automatic cmp_all(string req);
    for (int k = 0; k < L; k++)
      check(lane_out(k) == ref_lane(k, ncur), req, lane_out(k), ref_lane(k, ncur));
  endtask

  task automatic t_reset();
    check(res == '0, "R1 results", int'(res[31:0]), 0);
    check(valid == 1'b0, "R1 valid", int'(valid), 0);
    for (int j = 0; j < T; j++) cf[j] = j + 1;
    do_compute(15);
    cmp_all("R1 window zero");
  endtask

  task automatic t_taps();
    int nl [6] = '{3, 6, 9, 13, 15, 1};
    for (int s = 1; s <= 3; s++) do_shift(s);
    foreach (nl[i]) begin
      for (int j = 0; j < T; j++) cf[j] = ((i * 53 + j * 29) % 1024) - 512;
      do_compute(nl[i]);
      check(valid == 1'b1, "R7 valid after compute", int'(valid), 1);
      cmp_all("R4 taps");
    end
    @(posedge clk); @(negedge clk);
    check(valid == 1'b0, "R7 valid drops", int'(valid), 0);
  endtask

  task automatic t_shift_path();
    // one-hot coefficient walks every entry through the lanes
    for (int p = 0; p < T; p += 7) begin
      for (int j = 0; j < T; j++) cf[j] = (j == p) ? 1 : 0;
      do_shift(10 + p);
      do_compute(15);
      cmp_all("R2 shifted entries");
    end
  endtask

  task automatic t_ignore_high();
    logic [L*AW-1:0] first;
    for (int j = 0; j < T; j++) cf[j] = (j < 3) ? (j * 40 - 41) : 0;
    do_compute(3);
    first = res;
    cmp_all("R5 base");
    for (int j = 3; j < T; j++) cf[j] = 511 - j;
    do_compute(3);
    check(res == first, "R5 high coefs ignored", int'(res[31:0]), int'(first[31:0]));
  endtask

  task automatic t_zero_taps();
    for (int j = 0; j < T; j++) cf[j] = 100;
    do_compute(0);
    check(res == '0, "R6 zero taps", int'(res[31:0]), 0);
  endtask

  task automatic t_hold();
    logic [L*AW-1:0] held;
    for (int j = 0; j < T; j++) cf[j] = 3 - j;
    do_compute(9);
    held = res;
    cmp_all("R4 before hold");
    for (int j = 0; j < T; j++) cf[j] = -j;
    pack_coef(); taps = 4'd13;
    for (int i = 0; i < L; i++) chunk[i*PW +: PW] = 10'(i * 9);
    repeat (3) begin @(posedge clk); @(negedge clk); end
    check(res == held, "R8 results held", int'(res[31:0]), int'(held[31:0]));
    check(valid == 1'b0, "R7 valid idle", int'(valid), 0);
    for (int j = 0; j < T; j++) cf[j] = 3 - j;
    do_compute(9);
    check(res == held, "R3 window held", int'(res[31:0]), int'(held[31:0]));
  endtask

  task automatic t_same_cycle();
    for (int j = 0; j < T; j++) cf[j] = 2 * j - 7;
    ncur = 6; taps = 4'd6; pack_coef();
    for (int j = 0; j < L; j++) chunk[j*PW +: PW] = 10'(pat(77, j));
    shift = 1'b1; compute = 1'b1;
    @(posedge clk); @(negedge clk);
    shift = 1'b0; compute = 1'b0;
    cmp_all("R9 old window used");
    for (int i = 0; i < D - L; i++) ref_e[i] = ref_e[i + L];
    for (int j = 0; j < L; j++) ref_e[D - L + j] = pat(77, j);
    do_compute(6);
    cmp_all("R9 new window next");
  endtask

  task automatic t_extremes();
    for (int s = 0; s < 3; s++) begin
      chunk = '1; shift = 1'b1;
      @(posedge clk); @(negedge clk);
      shift = 1'b0;
    end
    for (int i = 0; i < D; i++) ref_e[i] = 1023;
    for (int j = 0; j < T; j++) cf[j] = -512;
    do_compute(15);
    check(lane_out(15) == -7856640, "R10 min", lane_out(15), -7856640);
    cmp_all("R10 min lanes");
    for (int j = 0; j < T; j++) cf[j] = 511;
    do_compute(15);
    check(lane_out(0) == 7841295, "R10 max", lane_out(0), 7841295);
  endtask

  task automatic finish_run();
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: got timeout expected completion");
      finish_run();
    end
  end

  initial begin
    for (int i = 0; i < D; i++) ref_e[i] = 0;
    for (int j = 0; j < T; j++) cf[j] = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_taps();
    t_shift_path();
    t_ignore_high();
    t_zero_taps();
    t_hold();
    t_same_cycle();
    t_extremes();
    finish_run();
  end
endmodule